// File: doc/BRIEF.md
# Sign-Extending Halfword Load Unit

This unit runs one instruction family from a 32-bit big-endian RISC instruction set. Every member loads a signed 16-bit quantity from byte-addressed memory and widens it to 64 bits. The family has four members. Two take a 16-bit signed displacement and two take an index register. One of each kind also writes the computed address back into its base register. The unit holds a 32-entry, 64-bit register file.

An instruction word is presented while the unit is idle. The unit decodes it and forms the effective address. It then fetches the two bytes of the halfword with two separate requests, each returning one byte. It writes the sign-extended result, and for the update forms it also writes the new base. Finally it pulses `done`. A word outside the family instead pulses `illegal` and changes nothing.

The register file also has one write port and one asynchronous read port that other execution units share. The bench uses these to preload operands and to read back results.

Top module: `shload_unit`

## Requirements
- R1: Major opcode 42 (instruction bits 31:26, LSB numbering) loads without update. The destination is bits 25:21, the base is bits 20:16 and the signed displacement is bits 15:0. Only the destination register changes.
- R2: Major opcode 43 loads like R1 and also writes the effective address into the base register.
- R3: Major opcode 31 with extended opcode 343 in bits 10:1 and bit 0 clear is the indexed load without update. The index register is bits 15:11, and the address is base plus index.
- R4: Major opcode 31 with extended opcode 375 in bits 10:1 and bit 0 clear is the indexed load with update, writing the effective address into the base register.
- R5: In the two non-update forms, a base field of 0 supplies the constant zero. In the two update forms, register 0 is read like any other register.
- R6: The base-plus-offset sum is computed at 64 bits, and only its low 32 bits form the effective address. An update writes that 32-bit address zero-extended to 64 bits.
- R7: The first memory request is at the effective address and supplies bits 15:8 of the halfword. The second request is at the effective address plus one, wrapping at 32 bits, and supplies bits 7:0.
- R8: The 16-bit value is sign-extended to 64 bits before it is written to the destination.
- R9: When an update form names the same register as base and destination, that register ends up holding the effective address.
- R10: Odd effective addresses, including 0xFFFFFFFF, complete normally with no fault.
- R11: Any other word raises `illegal` for exactly one cycle. It issues no memory request and leaves every register unchanged.
- R12: `done` is high for exactly one cycle, after all register writes of the instruction. A request held without `memReqReady` keeps `memReqValid` and `memAddr` steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word present; taken when busy is low |
| instrWord | input | 32 | Instruction word |
| busy | output | 1 | Unit is executing an instruction |
| done | output | 1 | One-cycle pulse when a load has finished all writes |
| illegal | output | 1 | One-cycle pulse for an undecodable word |
| memReqValid | output | 1 | Byte read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memAddr | output | 32 | Byte address of the request |
| memRespValid | input | 1 | Returned byte valid |
| memRespData | input | 8 | Returned byte |
| rfWrEn | input | 1 | Shared register-file write enable (use while idle) |
| rfWrAddr | input | 5 | Shared write register number |
| rfWrData | input | 64 | Shared write data |
| rfRdAddr | input | 5 | Shared read register number |
| rfRdData | output | 64 | Shared read data (combinational) |

## Verification
The bench aims at the special operand rules. A base field of zero must give constant zero in the non-update forms but must read register 0 in the update forms. A design that confused these would load from the wrong address or would leave register 0 unchanged. The bench also uses a base value above 32 bits and an address of 0xFFFFFFFF. A design that kept high address bits, or did not wrap the second byte address, would show the wrong request addresses or the wrong written-back base. Halfwords with the top bit both set and clear, read at odd addresses, expose a missing sign extension, a swapped byte order or a spurious alignment stall. A base equal to the destination checks the write order: getting it wrong leaves the loaded data where the address should be. Rejected encodings, including a sibling extended opcode and a set record bit, must pulse `illegal` without touching memory or registers.

// File: rtl/shload_pkg.sv
package shload_pkg;

  localparam logic [5:0] OP_DISP     = 6'd42;
  localparam logic [5:0] OP_DISP_UPD = 6'd43;
  localparam logic [5:0] OP_EXT      = 6'd31;
  localparam logic [9:0] XO_IDX      = 10'd343;
  localparam logic [9:0] XO_IDX_UPD  = 10'd375;

  typedef enum logic [2:0] {
    K_ILLEGAL,
    K_DISP,
    K_DISP_UPD,
    K_IDX,
    K_IDX_UPD
  } kind_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic latchFields;
    logic latchEa;
    logic latchHi;
    logic latchLo;
    logic wrDst;
    logic wrBase;
    logic selLo;
    logic useIndex;
    logic update;
  } strobe_t;

  // ext holds instruction bits 10:0 (extended opcode in 10:1, record bit in 0)
  function automatic kind_e decodeKind(input logic [5:0] major, input logic [10:0] ext);
    kind_e k;
    k = K_ILLEGAL;
    case (major)
      OP_DISP:     k = K_DISP;
      OP_DISP_UPD: k = K_DISP_UPD;
      OP_EXT: begin
        if (!ext[0] && ext[10:1] == XO_IDX)     k = K_IDX;
        if (!ext[0] && ext[10:1] == XO_IDX_UPD) k = K_IDX_UPD;
      end
      default: k = K_ILLEGAL;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/shload_ctrl.sv
module shload_ctrl
  import shload_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [5:0]  major,
  input  logic [10:0] ext,
  input  logic        memReqReady,
  input  logic        memRespValid,
  output strobe_t     stb,
  output logic        memReqValid,
  output logic        busy,
  output logic        done,
  output logic        illegal
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_REQ_HI, S_WAIT_HI, S_REQ_LO, S_WAIT_LO,
    S_WR_DST, S_WR_BASE, S_FIN, S_ILL
  } state_e;

  state_e stateQ, stateD;
  kind_e  kindQ, kindD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      kindQ  <= K_ILLEGAL;
    end else begin
      stateQ <= stateD;
      kindQ  <= kindD;
    end
  end

  always_comb begin
    stateD      = stateQ;
    kindD       = kindQ;
    stb         = '0;
    stb.update  = (kindQ == K_DISP_UPD) || (kindQ == K_IDX_UPD);
    stb.useIndex = (kindQ == K_IDX) || (kindQ == K_IDX_UPD);
    memReqValid = 1'b0;
    done        = 1'b0;
    illegal     = 1'b0;
    busy        = (stateQ != S_IDLE);
    case (stateQ)
      S_IDLE: begin
        if (instrValid) begin
          kindD = decodeKind(major, ext);
          stb.latchFields = 1'b1;
          stateD = (kindD == K_ILLEGAL) ? S_ILL : S_ADDR;
        end
      end
      S_ADDR: begin
        stb.latchEa = 1'b1;
        stateD = S_REQ_HI;
      end
      S_REQ_HI: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = S_WAIT_HI;
      end
      S_WAIT_HI: begin
        if (memRespValid) begin
          stb.latchHi = 1'b1;
          stateD = S_REQ_LO;
        end
      end
      S_REQ_LO: begin
        memReqValid = 1'b1;
        stb.selLo = 1'b1;
        if (memReqReady) stateD = S_WAIT_LO;
      end
      S_WAIT_LO: begin
        if (memRespValid) begin
          stb.latchLo = 1'b1;
          stateD = S_WR_DST;
        end
      end
      S_WR_DST: begin
        stb.wrDst = 1'b1;
        stateD = stb.update ? S_WR_BASE : S_FIN;
      end
      S_WR_BASE: begin
        stb.wrBase = 1'b1;
        stateD = S_FIN;
      end
      S_FIN: begin
        done = 1'b1;
        stateD = S_IDLE;
      end
      S_ILL: begin
        illegal = 1'b1;
        stateD = S_IDLE;
      end
      default: stateD = S_IDLE;
    endcase
  end

endmodule

// File: rtl/shload_dp.sv
module shload_dp
  import shload_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 32,
  parameter int NREG = 32,
  localparam int RIDX = $clog2(NREG),
  localparam int HALF = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [25:0]     fieldsIn,
  input  logic [7:0]      memRespData,
  input  logic            rfWrEn,
  input  logic [RIDX-1:0] rfWrAddr,
  input  logic [XLEN-1:0] rfWrData,
  input  logic [RIDX-1:0] rfRdAddr,
  output logic [XLEN-1:0] rfRdData,
  output logic [AW-1:0]   memAddr
);

  logic [XLEN-1:0] rf [NREG];
  logic [25:0]     fieldsQ;
  logic [AW-1:0]   eaQ;
  logic [7:0]      hiQ, loQ;

  logic [RIDX-1:0] rtF, raF, rbF;
  logic [HALF-1:0] dispF;
  logic [XLEN-1:0] baseVal, offVal, sum, loadVal, baseWb;

  assign rtF   = fieldsQ[21 +: RIDX];
  assign raF   = fieldsQ[16 +: RIDX];
  assign rbF   = fieldsQ[11 +: RIDX];
  assign dispF = fieldsQ[HALF-1:0];

  // non-update forms treat base field zero as constant zero
  assign baseVal = (!stb.update && raF == '0) ? '0 : rf[raF];
  assign offVal  = stb.useIndex ? rf[rbF] : {{(XLEN-HALF){dispF[HALF-1]}}, dispF};
  assign sum     = baseVal + offVal;
  assign loadVal = {{(XLEN-HALF){hiQ[7]}}, hiQ, loQ};
  assign baseWb  = {{(XLEN-AW){1'b0}}, eaQ};

  assign memAddr  = stb.selLo ? eaQ + AW'(1) : eaQ;
  assign rfRdData = rf[rfRdAddr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldsQ <= '0;
      eaQ     <= '0;
      hiQ     <= '0;
      loQ     <= '0;
    end else begin
      if (stb.latchFields) fieldsQ <= fieldsIn;
      if (stb.latchEa)     eaQ     <= sum[AW-1:0];
      if (stb.latchHi)     hiQ     <= memRespData;
      if (stb.latchLo)     loQ     <= memRespData;
    end
  end

  // destination first, base second: a shared register keeps the address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (stb.wrDst) begin
      rf[rtF] <= loadVal;
    end else if (stb.wrBase) begin
      rf[raF] <= baseWb;
    end else if (rfWrEn) begin
      rf[rfWrAddr] <= rfWrData;
    end
  end

endmodule

// File: rtl/shload_unit.sv
module shload_unit
  import shload_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 32,
  parameter int NREG = 32,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instrValid,
  input  logic [31:0]     instrWord,
  output logic            busy,
  output logic            done,
  output logic            illegal,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic [AW-1:0]   memAddr,
  input  logic            memRespValid,
  input  logic [7:0]      memRespData,
  input  logic            rfWrEn,
  input  logic [RIDX-1:0] rfWrAddr,
  input  logic [XLEN-1:0] rfWrData,
  input  logic [RIDX-1:0] rfRdAddr,
  output logic [XLEN-1:0] rfRdData
);

  strobe_t stb;

  shload_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .instrValid   (instrValid),
    .major        (instrWord[31:26]),
    .ext          (instrWord[10:0]),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .stb          (stb),
    .memReqValid  (memReqValid),
    .busy         (busy),
    .done         (done),
    .illegal      (illegal)
  );

  shload_dp #(.XLEN(XLEN), .AW(AW), .NREG(NREG)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .fieldsIn    (instrWord[25:0]),
    .memRespData (memRespData),
    .rfWrEn      (rfWrEn),
    .rfWrAddr    (rfWrAddr),
    .rfWrData    (rfWrData),
    .rfRdAddr    (rfRdAddr),
    .rfRdData    (rfRdData),
    .memAddr     (memAddr)
  );

endmodule

// File: rtl/shload_chk.sv
module shload_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          done,
  input logic          illegal,
  input logic          memReqValid,
  input logic          memReqReady,
  input logic [AW-1:0] memAddr
);

  logic          secondReq;
  logic [AW-1:0] firstAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secondReq <= 1'b0;
      firstAddr <= '0;
    end else if (memReqValid && memReqReady) begin
      secondReq <= !secondReq;
      if (!secondReq) firstAddr <= memAddr;
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R11
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) illegal |=> !illegal);

  // R11
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!memReqValid && !done));

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memAddr)));

  // R7
  second_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady && secondReq) |-> (memAddr == firstAddr + AW'(1)));

endmodule

bind shload_unit shload_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .done        (done),
  .illegal     (illegal),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memAddr     (memAddr)
);

// File: tb/sim_shload_unit.sv
module sim_shload_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        busy, done, illegal, memReqValid;
  logic        memReqReady;
  logic [31:0] memAddr;
  logic        memRespValid = 1'b0;
  logic [7:0]  memRespData = '0;
  logic        rfWrEn = 1'b0;
  logic [4:0]  rfWrAddr = '0;
  logic [63:0] rfWrData = '0;
  logic [4:0]  rfRdAddr = '0;
  logic [63:0] rfRdData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shload_unit u0 (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .busy(busy), .done(done), .illegal(illegal),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memAddr(memAddr),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr), .rfWrData(rfWrData),
    .rfRdAddr(rfRdAddr), .rfRdData(rfRdData)
  );

  // memory model: stalls half the time, answers one cycle after acceptance
  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'h93;
  endfunction

  logic [1:0]  stallCnt = '0;
  int          reqCount = 0;
  logic [31:0] prevReqAddr = '0, lastReqAddr = '0;
  assign memReqReady = stallCnt[1];

  always @(posedge clk) begin
    stallCnt     <= stallCnt + 2'd1;
    memRespValid <= 1'b0;
    if (memReqValid && memReqReady) begin
      memRespValid <= 1'b1;
      memRespData  <= memByte(memAddr);
      prevReqAddr  <= lastReqAddr;
      lastReqAddr  <= memAddr;
      reqCount     <= reqCount + 1;
    end
  end

  function automatic logic [31:0] encD(input logic [5:0] op, input logic [4:0] rt,
                                       input logic [4:0] ra, input logic [15:0] d);
    return {op, rt, ra, d};
  endfunction

  function automatic logic [31:0] encX(input logic [4:0] rt, input logic [4:0] ra,
                                       input logic [4:0] rb, input logic [9:0] xo);
    return {6'd31, rt, ra, rb, xo, 1'b0};
  endfunction

  function automatic logic [63:0] expLoad(input logic [31:0] ea);
    logic [15:0] h;
    h = {memByte(ea), memByte(ea + 32'd1)};
    return {{48{h[15]}}, h};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setReg(input logic [4:0] idx, input logic [63:0] val);
    @(negedge clk);
    rfWrEn = 1'b1; rfWrAddr = idx; rfWrData = val;
    @(negedge clk);
    rfWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] idx, output logic [63:0] val);
    @(negedge clk);
    rfRdAddr = idx;
    #1 val = rfRdData;
  endtask

  // issues a word; reports whether done or illegal pulsed, requests made,
  // and whether that pulse dropped after one cycle
  task automatic issue(input logic [31:0] word, output bit sawDone, output bit sawIll,
                       output int reqs, output bit oneCycle);
    int startCnt;
    sawDone = 1'b0; sawIll = 1'b0; oneCycle = 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    startCnt = reqCount;
    instrValid = 1'b1; instrWord = word;
    @(negedge clk);
    instrValid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done || illegal) begin
        sawDone = done; sawIll = illegal;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    oneCycle = !done && !illegal;
    reqs = reqCount - startCnt;
  endtask

  task automatic runLoad(input string tag, input logic [31:0] word, input logic [31:0] ea,
                         input logic [4:0] rt, input logic [4:0] ra,
                         input logic [63:0] expRa, input bit checkRt);
    bit d, il, one;
    int reqs;
    logic [63:0] v;
    issue(word, d, il, reqs, one);
    check({tag, " R12 done pulse"}, {62'd0, d, one}, {62'd0, 2'b11});
    check({tag, " R7 request count"}, 64'(reqs), 64'd2);
    check({tag, " R7 first byte address"}, {32'd0, prevReqAddr}, {32'd0, ea});
    check({tag, " R7 second byte address"}, {32'd0, lastReqAddr}, {32'd0, ea + 32'd1});
    if (checkRt) begin
      readReg(rt, v);
      check({tag, " R8 destination"}, v, expLoad(ea));
    end
    readReg(ra, v);
    check({tag, " base register"}, v, expRa);
  endtask

  task automatic testReset();
    logic [63:0] v;
    check("R12 reset outputs", {60'd0, busy, done, illegal, memReqValid}, 64'd0);
    readReg(5'd3, v);
    check("R11 reset register", v, 64'd0);
  endtask

  task automatic testDispPlain();
    // R1: negative halfword at 0x1010
    setReg(5'd4, 64'h1000);
    runLoad("R1 lha", encD(6'd42, 5'd3, 5'd4, 16'h0010), 32'h1010, 5'd3, 5'd4, 64'h1000, 1'b1);
    // R8: positive halfword, base field zero gives constant zero (R5)
    setReg(5'd0, 64'h7777);
    runLoad("R8 R5 lha positive", encD(6'd42, 5'd18, 5'd0, 16'h0093), 32'h93, 5'd18, 5'd0,
            64'h7777, 1'b1);
  endtask

  task automatic testDispUpdate();
    setReg(5'd6, 64'h2000);
    runLoad("R2 lhau", encD(6'd43, 5'd5, 5'd6, 16'hFFFE), 32'h1FFE, 5'd5, 5'd6,
            64'h1FFE, 1'b1);
  endtask

  task automatic testIndexed();
    setReg(5'd0, 64'h5555);
    setReg(5'd8, 64'h3001);
    runLoad("R3 R5 R10 lhax odd", encX(5'd7, 5'd0, 5'd8, 10'd343), 32'h3001, 5'd7, 5'd0,
            64'h5555, 1'b1);
    setReg(5'd0, 64'h100);
    setReg(5'd10, 64'h21);
    runLoad("R4 R5 lhaux r0 base", encX(5'd9, 5'd0, 5'd10, 10'd375), 32'h121, 5'd9, 5'd0,
            64'h121, 1'b1);
  endtask

  task automatic testWrap();
    setReg(5'd12, 64'hFFFF_FFFF_FFFF_FFFE);
    runLoad("R6 lha wrap", encD(6'd42, 5'd11, 5'd12, 16'h0004), 32'h2, 5'd11, 5'd12,
            64'hFFFF_FFFF_FFFF_FFFE, 1'b1);
    setReg(5'd14, 64'h0000_0001_FFFF_FFF0);
    setReg(5'd15, 64'h20);
    runLoad("R6 lhaux high bits", encX(5'd13, 5'd14, 5'd15, 10'd375), 32'h10, 5'd13, 5'd14,
            64'h10, 1'b1);
    runLoad("R10 lha top address", encD(6'd42, 5'd16, 5'd0, 16'hFFFF), 32'hFFFF_FFFF,
            5'd16, 5'd0, 64'h21 + 64'h100, 1'b1);
  endtask

  task automatic testSameReg();
    setReg(5'd17, 64'h4000);
    runLoad("R9 lhau rt==ra", encD(6'd43, 5'd17, 5'd17, 16'h0002), 32'h4002, 5'd17, 5'd17,
            64'h4002, 1'b0);
  endtask

  task automatic testIllegal();
    bit d, il, one;
    int reqs;
    logic [63:0] v3, v;
    logic [31:0] bad [3];
    bad[0] = encX(5'd3, 5'd4, 5'd8, 10'd279);          // sibling extended opcode
    bad[1] = encD(6'd40, 5'd3, 5'd4, 16'h0010);        // neighbouring major opcode
    bad[2] = encX(5'd3, 5'd4, 5'd8, 10'd343) | 32'd1;  // record bit set
    readReg(5'd3, v3);
    for (int k = 0; k < 3; k++) begin
      issue(bad[k], d, il, reqs, one);
      check("R11 illegal pulse", {61'd0, il, d, one}, {61'd0, 3'b101});
      check("R11 no memory request", 64'(reqs), 64'd0);
      readReg(5'd3, v);
      check("R11 destination unchanged", v, v3);
      readReg(5'd4, v);
      check("R11 base unchanged", v, 64'h1000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDispPlain();
    testDispUpdate();
    testIndexed();
    testWrap();
    testSameReg();
    testIllegal();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule